// File: doc/BRIEF.md
# Programmable-Format Serial Transmitter

This block is the transmit half of one asynchronous serial channel. A host writes bytes into a small buffer. The block takes them out one at a time, adds a low start bit, sends the data bits least significant first, adds an optional parity bit, and then sends a high stop period on the `txd` line. Bit timing comes from an external enable pulse that runs at sixteen times the bit rate.

The character format can be changed at run time: data length, parity kind and stop length. The format is captured when a character leaves the buffer, so a change made while a frame is going out only affects later characters. The buffer holds sixteen entries in buffered mode and one entry in unbuffered mode. A break input holds the line low without stopping the shifter. A ready flag with hysteresis tells a DMA engine when to refill the buffer. An empty flag reports when the channel has gone fully quiet.

Top module: `uart_tx_fmt`

## Requirements
- R1: Each character starts with one low start bit. The data bits follow, least significant first, and their number is set by `char_len` (0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8). Each start, data and parity bit lasts exactly 16 `baud_tick` pulses.
- R2: When `par_en` is 1, a parity bit follows the last data bit. With `par_odd`=0, the count of ones in the data bits plus the parity bit is even. With `par_odd`=1, that count is odd. When `par_en` is 0, no parity bit is sent.
- R3: The stop period is high. It lasts 16 ticks when `stop_long`=0. It lasts 24 ticks when `stop_long`=1 with 5-bit characters, and 32 ticks when `stop_long`=1 with 6-, 7- or 8-bit characters.
- R4: The line sits high whenever nothing is being sent and `brk` is low, including right after reset.
- R5: When `fifo_en`=1, the buffer holds up to 16 bytes and sends them in write order. A write to a full buffer is dropped, and the stored bytes are left unchanged.
- R6: When `fifo_en`=0, the buffer is a single holding entry. A write while that entry is occupied is dropped. A write in the same cycle that the entry moves to the shifter is accepted.
- R7: While `brk` is 1, `txd` is low. The shifter keeps running, so the frame that is in progress finishes on time underneath the break.
- R8: `tx_rdy` is 1 after reset and whenever the buffer is empty. It is 0 whenever the buffer is full. Between those two states it keeps its last value.
- R9: `tx_empty` is 1 only when both the buffer and the shifter are empty. It is 0 while a character is still being shifted out, even after the buffer has emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle enable at 16 pulses per bit |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Byte to send |
| fifo_en | input | 1 | 1 = 16-entry buffer, 0 = single holding entry |
| char_len | input | 2 | Data length code (0 to 3 gives 5 to 8 bits) |
| par_en | input | 1 | Adds a parity bit when 1 |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop_long | input | 1 | 0 = one stop bit; 1 = 1.5 stop bits (5-bit characters) or 2 stop bits (longer characters) |
| brk | input | 1 | Forces the line low while 1 |
| txd | output | 1 | Serial output |
| tx_rdy | output | 1 | Ready flag for DMA refill |
| tx_empty | output | 1 | Buffer and shifter both empty |

## Verification
A host write and the shifter's load from the buffer can fall in the same cycle. When that happens, the write must be accepted even though the buffer looked full one cycle earlier.

The bench provokes this in two ways:
- It writes back-to-back bursts into an empty channel in buffered mode. The first byte moves to the shifter while the second byte arrives.
- It writes three back-to-back bytes in single-entry mode.

Each case is judged by the exact characters that appear on the line: 17 bytes out of a 20-byte burst, and two bytes out of three. No further frame must follow, and the ready flag must read low during the fill.

// File: rtl/uart_tx_fmt.sv
module uart_tx_fmt #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int OSR   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          fifo_en,
  input  logic [1:0]    char_len,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          stop_long,
  input  logic          brk,
  output logic          txd,
  output logic          tx_rdy,
  output logic          tx_empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(OSR);
  localparam int SW = $clog2(2 * OSR + 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(OSR - 1);
  localparam logic [SW-1:0] STOP_ONE  = SW'(OSR);
  localparam logic [SW-1:0] STOP_HALF = SW'(OSR + OSR / 2);
  localparam logic [SW-1:0] STOP_TWO  = SW'(2 * OSR);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, cnt_nx, cap;
  logic          rdy_q;
  st_t           st;
  logic [TW-1:0] tick_cnt;
  logic [SW-1:0] stop_cnt, stop_lim;
  logic [2:0]    bit_left;
  logic [DW-1:0] sh;
  logic          pbit, par_on;

  wire full    = cnt >= cap;
  wire pop     = (st == S_IDLE) && (cnt != '0);
  wire push    = wr_en && (!full || pop);
  wire bit_end = baud_tick && (tick_cnt == TICK_LAST);

  wire [DW-1:0] len_mask = {DW{1'b1}} >> (2'd3 - char_len);
  wire [DW-1:0] head     = mem[rptr] & len_mask;

  assign cap    = fifo_en ? CW'(DEPTH) : CW'(1);
  assign cnt_nx = cnt + CW'(push) - CW'(pop);

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt   <= '0;
      rdy_q <= 1'b1;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      cnt <= cnt_nx;
      if (cnt_nx == '0)      rdy_q <= 1'b1;
      else if (cnt_nx >= cap) rdy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tick_cnt <= '0;
      stop_cnt <= '0;
      stop_lim <= STOP_ONE;
      bit_left <= '0;
      sh       <= '0;
      pbit     <= 1'b0;
      par_on   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (pop) begin
          st       <= S_START;
          tick_cnt <= '0;
          sh       <= head;
          pbit     <= (^head) ^ par_odd;
          par_on   <= par_en;
          bit_left <= {1'b0, char_len} + 3'd4;
          stop_lim <= !stop_long ? STOP_ONE : (char_len == 2'd0) ? STOP_HALF : STOP_TWO;
        end
        S_START: begin
          if (baud_tick) tick_cnt <= tick_cnt + 1'b1;
          if (bit_end) st <= S_DATA;
        end
        S_DATA: begin
          if (baud_tick) tick_cnt <= tick_cnt + 1'b1;
          if (bit_end) begin
            if (bit_left == '0) begin
              st       <= par_on ? S_PAR : S_STOP;
              stop_cnt <= '0;
            end else begin
              sh       <= sh >> 1;
              bit_left <= bit_left - 1'b1;
            end
          end
        end
        S_PAR: begin
          if (baud_tick) tick_cnt <= tick_cnt + 1'b1;
          if (bit_end) begin
            st       <= S_STOP;
            stop_cnt <= '0;
          end
        end
        S_STOP: if (baud_tick) begin
          stop_cnt <= stop_cnt + 1'b1;
          if (stop_cnt == stop_lim - 1'b1) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign txd = !brk && ((st == S_IDLE) || (st == S_STOP) ||
                        (st == S_DATA && sh[0]) || (st == S_PAR && pbit));
  assign tx_rdy   = rdy_q;
  assign tx_empty = (cnt == '0) && (st == S_IDLE);
endmodule

// File: rtl/uart_tx_fmt_chk.sv
module uart_tx_fmt_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       brk,
  input logic                       fifo_en,
  input logic                       txd,
  input logic                       tx_rdy,
  input logic                       tx_empty,
  input logic [$clog2(DEPTH+1)-1:0] cnt
);
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd); // R7
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !brk) |-> txd); // R4
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty) |=> (brk || !txd)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($clog2(DEPTH+1))'(DEPTH)); // R5
  AST_RDY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> tx_rdy); // R8
  AST_RDY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(fifo_en) && cnt >= (fifo_en ? ($clog2(DEPTH+1))'(DEPTH) : ($clog2(DEPTH+1))'(1))) |-> !tx_rdy); // R8
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (cnt == '0)); // R9
endmodule

bind uart_tx_fmt uart_tx_fmt_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .brk(brk), .fifo_en(fifo_en), .txd(txd),
  .tx_rdy(tx_rdy), .tx_empty(tx_empty), .cnt(cnt)
);

// File: tb/sim_uart_tx_fmt.sv
module sim_uart_tx_fmt;
  logic clk = 0, rst_n = 0, baud_tick = 0, wr_en = 0, fifo_en = 1;
  logic [7:0] wr_data = 0;
  logic [1:0] char_len = 2'd3;
  logic par_en = 0, par_odd = 0, stop_long = 0, brk = 0;
  logic txd, tx_rdy, tx_empty;
  int nchk = 0, nfail = 0;
  logic samp [256];

  always #2 clk = ~clk;

  uart_tx_fmt u0 (.clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .fifo_en(fifo_en), .char_len(char_len), .par_en(par_en),
    .par_odd(par_odd), .stop_long(stop_long), .brk(brk), .txd(txd),
    .tx_rdy(tx_rdy), .tx_empty(tx_empty));

  // {char_len, par_en, par_odd, stop_long, data}
  localparam logic [12:0] VEC [8] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 8'h15}, {2'd0, 1'b1, 1'b0, 1'b1, 8'h0B},
    {2'd1, 1'b1, 1'b1, 1'b0, 8'h2A}, {2'd1, 1'b0, 1'b0, 1'b1, 8'h3F},
    {2'd2, 1'b1, 1'b0, 1'b1, 8'h5A}, {2'd2, 1'b0, 1'b0, 1'b0, 8'h01},
    {2'd3, 1'b1, 1'b1, 1'b1, 8'hA5}, {2'd3, 1'b1, 1'b0, 1'b0, 8'hFF}};

  initial begin
    int t = 0;
    forever begin
      @(posedge clk); #1;
      t++;
      baud_tick = (t % 2 == 0);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  task automatic put(input logic [7:0] b);
    @(posedge clk); #1; wr_en = 1; wr_data = b;
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic burst(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; wr_en = 1; wr_data = base + 8'(i);
    end
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic cap_frame(input int maxn, input bit on_empty, output int n);
    int guard = 0;
    n = 0;
    @(negedge clk);
    while (txd !== 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
    if (guard >= 4000) return;
    forever begin
      if ((on_empty && tx_empty) || n == maxn || n == 255) break;
      if (baud_tick) begin samp[n] = txd; n++; end
      @(negedge clk);
    end
  endtask

  function automatic int get_data(input int len);
    int d = 0;
    for (int k = 0; k < len; k++) d |= int'(samp[16 * (k + 1) + 8]) << k;
    return d;
  endfunction

  task automatic quiet_check(input string req, input int cycles);
    int lows = 0;
    for (int i = 0; i < cycles; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
    chk(req, lows, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R4 reset line high", txd, 1);
    chk("R8 reset ready", tx_rdy, 1);
    chk("R9 reset empty", tx_empty, 1);
    @(posedge clk); #1 rst_n = 1;

    for (int i = 0; i < 8; i++) begin
      int len, p, exp_d, exp_stop, highs;
      logic [12:0] v = VEC[i];
      @(posedge clk); #1;
      char_len = v[12:11]; par_en = v[10]; par_odd = v[9]; stop_long = v[8];
      len = 5 + int'(v[12:11]);
      p = int'(v[10]);
      exp_d = int'(v[7:0]) & ((1 << len) - 1);
      exp_stop = !v[8] ? 16 : (v[12:11] == 2'd0) ? 24 : 32;
      fork put(v[7:0]); cap_frame(255, 1, n); join
      chk("R1 start bit low", samp[8], 0);
      chk("R1 data bits lsb first", get_data(len), exp_d);
      if (p) chk("R2 parity bit", samp[16 * (len + 1) + 8], ($countones(exp_d) + int'(v[9])) % 2);
      chk("R3 stop ticks", n - 16 * (1 + len + p), exp_stop);
      highs = 0;
      for (int k = 16 * (1 + len + p); k < n; k++) highs += int'(samp[k]);
      chk("R3 stop level high", highs, n - 16 * (1 + len + p));
      chk("R4 idle after frame", txd, 1);
    end

    // R7 break during a frame, plus R8/R9 with the shifter busy
    @(posedge clk); #1; char_len = 2'd3; par_en = 0; stop_long = 0;
    put(8'h55);
    repeat (40) @(negedge clk);
    chk("R9 empty low while shifting", tx_empty, 0);
    chk("R8 ready with buffer empty", tx_rdy, 1);
    @(posedge clk); #1 brk = 1;
    repeat (3) @(negedge clk);
    chk("R7 break forces low", txd, 0);
    repeat (400) @(negedge clk);
    chk("R7 break low after frame time", txd, 0);
    chk("R7 shifter ran under break", tx_empty, 1);
    @(posedge clk); #1 brk = 0;
    @(negedge clk);
    chk("R7 line released high", txd, 1);
    fork put(8'hC3); cap_frame(255, 1, n); join
    chk("R7 frame after break", get_data(8), 8'hC3);

    // R5 overfill: write then load in the same cycle, 17 of 20 kept
    fork
      begin
        burst(20, 8'h40);
        @(negedge clk);
        chk("R8 ready low when full", tx_rdy, 0);
      end
      begin
        for (int f = 0; f < 17; f++) begin
          cap_frame(160, 0, n);
          chk("R5 order and content", get_data(8), 8'h40 + f);
          if (f == 1) chk("R8 ready holds low below full", tx_rdy, 0);
        end
      end
    join
    repeat (20) @(negedge clk);
    chk("R9 empty after drain", tx_empty, 1);
    quiet_check("R5 dropped writes not sent", 400);

    // R6 single holding entry
    @(posedge clk); #1 fifo_en = 0;
    fork
      begin
        burst(3, 8'h90);
        @(negedge clk);
        chk("R6 ready low holding full", tx_rdy, 0);
      end
      begin
        cap_frame(160, 0, n);
        chk("R6 first byte", get_data(8), 8'h90);
        cap_frame(160, 0, n);
        chk("R6 byte written during load", get_data(8), 8'h91);
      end
    join
    repeat (20) @(negedge clk);
    chk("R6 empty after two", tx_empty, 1);
    quiet_check("R6 third write dropped", 400);
    chk("R8 ready after drain", tx_rdy, 1);
    finish_run();
  end
endmodule